// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block is the decision core of an eight-input interrupt controller. It captures request lines into a request register, either on rising edges or by following the line level. It drops requests that are masked and picks a winner under a priority order that can rotate. It compares that winner against the levels already in service and raises a single interrupt output when the winner may preempt.

A single-cycle acknowledge pulse does two things. It moves the winning level into the in-service register, and one cycle later it returns an 8-bit vector made from the high bits of a configured base and the winning level number. A command decoder outside the block drives strobes for:
- mask writes;
- end-of-interrupt commands, with specific, non-specific and rotating forms;
- special mask mode;
- poll.

After a poll command, the next acknowledge returns a status byte instead of a vector.

Top module: `irq_arbiter8`

## Requirements
- R1: After reset, the request, in-service and mask registers are all zero. Input 0 has the highest priority and input 7 the lowest. `irq_out` and `dout_valid` are low.
- R2: With `cfg_level` = 0, a 0-to-1 change on `irq_in[i]` sets `irr[i]` one clock later. An acknowledge of level i clears `irr[i]`. A line that stays high does not request again until it falls and rises.
- R3: With `cfg_level` = 1, `irr` copies `irq_in` one clock later, and an acknowledge does not clear it.
- R4: A mask bit of 1 (written with `mask_wr`) keeps that input from raising `irq_out`. The request bit is still recorded.
- R5: An acknowledge that finds a request to serve returns `{cfg_base[7:3], level}` on `dout`, with `dout_valid` high on the following cycle. It sets exactly one in-service bit, the one for the winning level.
- R6: In nested mode, `irq_out` rises only when the best unmasked request has strictly higher priority than every in-service level.
- R7: With `cfg_auto_eoi` = 1, an acknowledge returns the vector but leaves the in-service register unchanged.
- R8: A `cmd_wr` with `cmd_eoi` = 1 and `cmd_sel` = 0 clears the in-service bit that has the highest priority.
- R9: A `cmd_wr` with `cmd_eoi` = 1 and `cmd_sel` = 1 clears in-service bit `cmd_lvl`.
- R10: A `cmd_wr` with `cmd_rot` = 1 and `cmd_sel` = 1 makes level `cmd_lvl` the lowest priority. With `cmd_rot` = 1, `cmd_eoi` = 1 and `cmd_sel` = 0, the level just cleared becomes the lowest priority. In both cases the level after it becomes the highest.
- R11: With special mask mode on (`smm_wr` with `smm_en` = 1), any unmasked request whose level is not in service raises `irq_out`, whatever its priority.
- R12: After `poll_wr`, the next acknowledge returns the status byte: bit 7 is set when a request is being served, bits 6:3 are zero and bits 2:0 hold the level. That acknowledge serves the level as a normal acknowledge would. With nothing to serve, the byte is 0x00. Later acknowledges return vectors again.
- R13: An acknowledge with no request to serve returns `{cfg_base[7:3], 3'b111}` and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N | Request lines |
| cfg_level | input | 1 | 1 = level-sensitive requests, 0 = rising-edge requests |
| cfg_auto_eoi | input | 1 | 1 = acknowledge does not enter service |
| cfg_base | input | 8 | Vector base; bits 7:3 are used |
| mask_wr | input | 1 | Mask register write strobe |
| mask_data | input | N | New mask, 1 = blocked |
| cmd_wr | input | 1 | End-of-interrupt / rotation command strobe |
| cmd_eoi | input | 1 | Command clears an in-service bit |
| cmd_sel | input | 1 | Command names a level explicitly |
| cmd_rot | input | 1 | Command changes the priority order |
| cmd_lvl | input | log2(N) | Level named by the command |
| smm_wr | input | 1 | Special mask mode write strobe |
| smm_en | input | 1 | New special mask mode setting |
| poll_wr | input | 1 | Poll command strobe |
| ack | input | 1 | Single-cycle acknowledge |
| irq_out | output | 1 | Interrupt to the processor |
| dout | output | 8 | Vector or poll status byte |
| dout_valid | output | 1 | `dout` holds the answer to the previous cycle's acknowledge |
| irr | output | N | Request register |
| isr | output | N | In-service register |

## Verification
The checker watches some rules on every cycle:
- an acknowledge is always answered on the next cycle;
- no cycle adds more than one in-service bit;
- automatic EOI never adds any;
- a specific end-of-interrupt always leaves its level clear;
- the interrupt output is never high without an unmasked request behind it.

Only the bench's scenarios can show the rest:
- which level wins under each rotation;
- the strict nesting comparison across all level pairs;
- rearming after an edge;
- the contents of the poll byte;
- the spurious response.

// File: rtl/irq_arbiter8.sv
module irq_arbiter8 #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         irq_in,
  input  logic                 cfg_level,
  input  logic                 cfg_auto_eoi,
  input  logic [7:0]           cfg_base,
  input  logic                 mask_wr,
  input  logic [N-1:0]         mask_data,
  input  logic                 cmd_wr,
  input  logic                 cmd_eoi,
  input  logic                 cmd_sel,
  input  logic                 cmd_rot,
  input  logic [$clog2(N)-1:0] cmd_lvl,
  input  logic                 smm_wr,
  input  logic                 smm_en,
  input  logic                 poll_wr,
  input  logic                 ack,
  output logic                 irq_out,
  output logic [7:0]           dout,
  output logic                 dout_valid,
  output logic [N-1:0]         irr,
  output logic [N-1:0]         isr
);
  localparam int LW = $clog2(N);

  logic [N-1:0]  line_q, mask_q;
  logic [LW-1:0] lowest_q;
  logic          smm_q, poll_q;

  logic [N-1:0]  cand;
  logic [LW-1:0] win, isr_top;
  logic [LW:0]   win_rank, isr_rank;
  logic          take;
  logic [N-1:0]  take_bit, eoi_clr;

  assign cand = smm_q ? (irr & ~mask_q & ~isr) : (irr & ~mask_q);

  always_comb begin
    logic [LW-1:0] idx;
    win      = '0;
    isr_top  = '0;
    win_rank = (LW+1)'(N);
    isr_rank = (LW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      idx = lowest_q + LW'(1) + LW'(k);
      if (cand[idx]) begin
        win      = idx;
        win_rank = (LW+1)'(k);
      end
      if (isr[idx]) begin
        isr_top  = idx;
        isr_rank = (LW+1)'(k);
      end
    end
  end

  assign irq_out  = (cand != '0) && (smm_q || win_rank < isr_rank);
  assign take     = ack && irq_out;
  assign take_bit = take ? (N'(1) << win) : '0;

  always_comb begin
    eoi_clr = '0;
    if (cmd_wr && cmd_eoi) begin
      if (cmd_sel)        eoi_clr = N'(1) << cmd_lvl;
      else if (isr != '0) eoi_clr = N'(1) << isr_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= '0;
      irr        <= '0;
      isr        <= '0;
      mask_q     <= '0;
      lowest_q   <= '1;
      smm_q      <= 1'b0;
      poll_q     <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      line_q <= irq_in;
      irr    <= cfg_level ? irq_in : ((irr & ~take_bit) | (irq_in & ~line_q));
      isr    <= (isr & ~eoi_clr) | (cfg_auto_eoi ? '0 : take_bit);
      if (mask_wr) mask_q <= mask_data;
      if (smm_wr)  smm_q  <= smm_en;
      if (cmd_wr && cmd_rot) begin
        if (cmd_sel)                    lowest_q <= cmd_lvl;
        else if (cmd_eoi && isr != '0)  lowest_q <= isr_top;
      end
      poll_q     <= poll_wr | (poll_q & ~ack);
      dout_valid <= ack;
      if (ack) begin
        if (poll_q)       dout <= {irq_out, (7-LW)'(0), irq_out ? win : LW'(0)};
        else if (irq_out) dout <= {cfg_base[7:LW], win};
        else              dout <= {cfg_base[7:LW], {LW{1'b1}}};
      end
    end
  end
endmodule

// File: rtl/irq_arbiter8_chk.sv
module irq_arbiter8_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack,
  input logic                 cfg_auto_eoi,
  input logic                 cmd_wr,
  input logic                 cmd_eoi,
  input logic                 cmd_sel,
  input logic [$clog2(N)-1:0] cmd_lvl,
  input logic                 irq_out,
  input logic                 dout_valid,
  input logic [N-1:0]         irr,
  input logic [N-1:0]         isr,
  input logic [N-1:0]         mask_q
);
  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) ack |=> dout_valid); // R5
  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $countones(isr & ~$past(isr)) <= 1); // R5
  AST_AUTO_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) cfg_auto_eoi |=> (isr & ~$past(isr)) == '0); // R7
  AST_SPEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && cmd_eoi && cmd_sel && !ack) |=> !isr[$past(cmd_lvl)]); // R9
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (irr & ~mask_q) != '0); // R4
endmodule

bind irq_arbiter8 irq_arbiter8_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .cfg_auto_eoi(cfg_auto_eoi),
  .cmd_wr(cmd_wr), .cmd_eoi(cmd_eoi), .cmd_sel(cmd_sel), .cmd_lvl(cmd_lvl),
  .irq_out(irq_out), .dout_valid(dout_valid), .irr(irr), .isr(isr), .mask_q(mask_q)
);

// File: tb/test_irq_arbiter8.sv
module test_irq_arbiter8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_level = 1'b0, cfg_auto_eoi = 1'b0;
  logic [7:0] cfg_base = 8'hA8;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_data = '0;
  logic       cmd_wr = 1'b0, cmd_eoi = 1'b0, cmd_sel = 1'b0, cmd_rot = 1'b0;
  logic [2:0] cmd_lvl = '0;
  logic       smm_wr = 1'b0, smm_en = 1'b0, poll_wr = 1'b0, ack = 1'b0;
  logic       irq_out, dout_valid;
  logic [7:0] dout, irr, isr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_arbiter8 #(.N(8)) i_irq_arbiter8 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_level(cfg_level),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_base(cfg_base), .mask_wr(mask_wr),
    .mask_data(mask_data), .cmd_wr(cmd_wr), .cmd_eoi(cmd_eoi), .cmd_sel(cmd_sel),
    .cmd_rot(cmd_rot), .cmd_lvl(cmd_lvl), .smm_wr(smm_wr), .smm_en(smm_en),
    .poll_wr(poll_wr), .ack(ack), .irq_out(irq_out), .dout(dout),
    .dout_valid(dout_valid), .irr(irr), .isr(isr)
  );

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic cmd(input logic e, input logic s, input logic r, input logic [2:0] l);
    cmd_eoi = e; cmd_sel = s; cmd_rot = r; cmd_lvl = l; cmd_wr = 1'b1;
    tick(); cmd_wr = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_data = m; mask_wr = 1'b1; tick(); mask_wr = 1'b0;
  endtask

  function automatic logic [7:0] vec(input int l);
    return (cfg_base & 8'hF8) | 8'(l);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); tick(2);
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    chk("R1 isr", isr, 8'h00);
    chk("R1 irr", irr, 8'h00);
    chk("R1 dout_valid", {7'd0, dout_valid}, 8'h00);
    rst_n = 1'b1; tick();

    // R2 R5 R8: edge mode sweep over each level
    for (int i = 0; i < 8; i++) begin
      irq_in = 8'(1 << i); tick();
      chk("R2 edge raises irq", {7'd0, irq_out}, 8'h01);
      pulse_ack();
      chk("R5 vector", dout, vec(i));
      chk("R5 valid", {7'd0, dout_valid}, 8'h01);
      chk("R5 isr entry", isr, 8'(1 << i));
      chk("R2 irr cleared", irr, 8'h00);
      cmd(1'b1, 1'b0, 1'b0, 3'd0);
      chk("R2 held line no rerequest", {7'd0, irq_out}, 8'h00);
      chk("R8 nonspecific eoi", isr, 8'h00);
      irq_in = '0; tick();
    end

    // R4 R9: masking each level
    for (int i = 0; i < 8; i++) begin
      set_mask(8'(1 << i));
      irq_in = 8'(1 << i); tick();
      chk("R4 masked no irq", {7'd0, irq_out}, 8'h00);
      chk("R4 request recorded", irr, 8'(1 << i));
      set_mask(8'h00);
      chk("R4 unmasked irq", {7'd0, irq_out}, 8'h01);
      pulse_ack();
      chk("R5 vector after unmask", dout, vec(i));
      cmd(1'b1, 1'b1, 1'b0, 3'(i));
      chk("R9 specific eoi", isr, 8'h00);
      irq_in = '0; tick();
    end

    // R3 R6: level mode, nesting over all ordered pairs
    cfg_level = 1'b1;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a == b) continue;
        irq_in = 8'(1 << a); tick();
        pulse_ack();
        chk("R3 level irr kept after ack", irr, 8'(1 << a));
        irq_in = 8'(1 << b); tick();
        chk("R6 nesting", {7'd0, irq_out}, (b < a) ? 8'h01 : 8'h00);
        if (b < a) begin
          pulse_ack();
          chk("R6 preempt vector", dout, vec(b));
          chk("R6 both in service", isr, 8'((1 << a) | (1 << b)));
          cmd(1'b1, 1'b1, 1'b0, 3'(b));
        end
        cmd(1'b1, 1'b1, 1'b0, 3'(a));
        chk("R9 cleared", isr, 8'h00);
        irq_in = '0; tick();
      end
    end

    // R10: rotation sweep
    irq_in = 8'hFF; tick();
    for (int r = 0; r < 8; r++) begin
      cmd(1'b0, 1'b1, 1'b1, 3'(r));
      pulse_ack();
      chk("R10 specific rotate winner", dout, vec((r + 1) % 8));
      cmd(1'b1, 1'b0, 1'b1, 3'd0);
      chk("R10 rotating eoi clears", isr, 8'h00);
      pulse_ack();
      chk("R10 rotate on eoi winner", dout, vec((r + 2) % 8));
      cmd(1'b1, 1'b1, 1'b0, 3'((r + 2) % 8));
    end
    cmd(1'b0, 1'b1, 1'b1, 3'd7);
    irq_in = '0; tick();

    // R7: automatic end of interrupt
    cfg_auto_eoi = 1'b1;
    irq_in = 8'h08; tick();
    pulse_ack();
    chk("R7 vector", dout, vec(3));
    chk("R7 no isr", isr, 8'h00);
    chk("R7 still requesting", {7'd0, irq_out}, 8'h01);
    cfg_auto_eoi = 1'b0;
    irq_in = '0; tick();

    // R11 R8: special mask mode
    irq_in = 8'h20; tick();
    pulse_ack();
    smm_en = 1'b1; smm_wr = 1'b1; tick(); smm_wr = 1'b0;
    chk("R11 in-service level excluded", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h60; tick();
    chk("R11 lower level interrupts", {7'd0, irq_out}, 8'h01);
    pulse_ack();
    chk("R11 lower vector", dout, vec(6));
    chk("R11 isr", isr, 8'h60);
    smm_en = 1'b0; smm_wr = 1'b1; tick(); smm_wr = 1'b0;
    cmd(1'b1, 1'b0, 1'b0, 3'd0);
    chk("R8 highest cleared first", isr, 8'h40);
    cmd(1'b1, 1'b0, 1'b0, 3'd0);
    irq_in = '0; tick();

    // R12 R13: poll and spurious acknowledge
    irq_in = 8'h50; tick();
    poll_wr = 1'b1; tick(); poll_wr = 1'b0;
    pulse_ack();
    chk("R12 poll byte", dout, 8'h84);
    chk("R12 poll serves", isr, 8'h10);
    pulse_ack();
    chk("R13 spurious vector", dout, vec(7));
    chk("R13 isr unchanged", isr, 8'h10);
    cmd(1'b1, 1'b1, 1'b0, 3'd4);
    irq_in = '0; tick();
    poll_wr = 1'b1; tick(); poll_wr = 1'b0;
    pulse_ack();
    chk("R12 empty poll", dout, 8'h00);
    chk("R12 empty poll isr", isr, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule